// File: doc/BRIEF.md
# MDIO PHY Link Monitor

This block runs a management bus to Ethernet PHYs with no software involved in any single transfer. It drives the serial clock and the data line and issues read frames one after another without a gap. Frames alternate between two jobs. One job is a discovery sweep that steps through all 32 PHY addresses and records in a bitmap which addresses answer. The other job is a status poll of one PHY chosen by the host.

Each poll takes the link bit from that PHY's basic status register. When the link bit differs from the stored value, the block sets a sticky event flag. That flag can drive an interrupt line. The host works only through a small word-wide register port. It selects the watched address, the interrupt enable and the clock divider. It reads the bitmap, the link bit and the event flag, and it acknowledges the event.

The block has no data stream that needs flow control. Every pin is a plain control or status signal. Register reads are combinational. A write takes effect on the clock edge where `reg_we` is high.

Top module: `mdio_link_monitor`

## Requirements
- R1: Each frame drives, MSB first: 32 ones, start bits 0 then 1, opcode 1 then 0, the 5-bit PHY address, then register address 1 (00001). `mdio_oe` is high for these 46 bits.
- R2: After the 46 driven bits, `mdio_oe` is low for 18 bit times: 2 turnaround bits, then 16 data bits taken MSB first from `mdio_i`. The next frame follows at once.
- R3: MDC is high for H system clocks and low for H system clocks. H is control bits [23:16], and a value of 0 acts as 1. `mdio_o` and `mdio_oe` change only when MDC falls. `mdio_i` is sampled when MDC rises.
- R4: The first frame after reset is a sweep read of address 0. After that, frames alternate between a poll of the watched address and the next sweep address. Sweep addresses count 0 to 31 and wrap.
- R5: Register 1 is the presence bitmap, 0 after reset. After each sweep read of address a, bit a becomes 1 if the 16 data bits are not all ones, and 0 if they are.
- R6: Status register 2, bit 0, holds data bit 2 of the most recent poll read. It is 0 after reset.
- R7: Status bit 1, the event flag, is set when a poll read returns a data bit 2 that differs from the stored link bit. The first poll that reads 1 after reset counts as a change. A poll that reads the same value leaves the flag as it is.
- R8: Writing register 2 with bit 1 set clears the event flag. Writing bit 1 as 0 has no effect. If a change arrives in the same cycle as the clear, the flag stays set.
- R9: `irq` equals the event flag ANDed with control bit 8.
- R10: Control register 0 holds the watched address in bits [4:0], the interrupt enable in bit 8 and the divider in bits [23:16]. Its reset value has address 0, enable 0 and divider DEF_HALF. Writes to the bitmap register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 bitmap, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in |
| irq | output | 1 | Link-change interrupt |

## Verification
The assertions check on every cycle that the data line and its enable move only on a falling MDC edge. They also check that the bitmap and the event flag change only after a completed read, and that a clear with no read landing in the same cycle leaves the flag low. Only the bench scenarios can show the bit-exact frame layout, the order of sweep and poll addresses, the MDC high and low times for two divider settings, and presence decoding for several PHY populations, including a PHY whose value is one bit short of all ones. The bench scenarios also cover link drop and link restore, and a clear timed to land in the same cycle as a new change.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;
  localparam int ADDR_W     = 5;
  localparam int PHY_CNT    = 1 << ADDR_W;
  localparam int FRAME_BITS = 64;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int DRIVE_BITS = 46;
  localparam int DATA_FIRST = 48;
  localparam int DATA_W     = 16;
  localparam int LINK_POS   = 2;
  localparam logic [ADDR_W-1:0] STATUS_REG = 5'd1;

  localparam logic [1:0] SEL_CTRL    = 2'd0;
  localparam logic [1:0] SEL_PRESENT = 2'd1;
  localparam logic [1:0] SEL_STATUS  = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic              mon;
  } frame_tag_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;
  logic              wrap;

  assign lim  = (half == '0) ? HALF_W'(1) : half;
  assign wrap = (cnt >= lim - HALF_W'(1));
  assign rise = wrap & ~mdc;
  assign fall = wrap & mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_sched.sv
module mdio_sched
  import mdio_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] watch,
  output frame_tag_t        next_tag
);
  logic              turn_mon;
  logic [ADDR_W-1:0] scan_ptr;

  assign next_tag.mon = turn_mon;
  assign next_tag.phy = turn_mon ? watch : scan_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      turn_mon <= 1'b0;
      scan_ptr <= '0;
    end else if (load) begin
      turn_mon <= ~turn_mon;
      if (!turn_mon) scan_ptr <= scan_ptr + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/mdio_read_engine.sv
module mdio_read_engine
  import mdio_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  frame_tag_t        next_tag,
  output logic              load,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output frame_tag_t        rd_tag
);
  logic                  run;
  logic [CNT_W-1:0]      bitcnt;
  frame_tag_t            tag_q;
  logic [DATA_W-1:0]     shreg;
  logic [DRIVE_BITS-1:0] hdr;
  logic [CNT_W-1:0]      hdr_idx;
  logic                  last_bit;

  assign last_bit = (bitcnt == CNT_W'(FRAME_BITS - 1));
  assign load     = fall & (~run | last_bit);
  assign hdr      = {32'hFFFF_FFFF, 2'b01, 2'b10, tag_q.phy, STATUS_REG};
  assign hdr_idx  = CNT_W'(DRIVE_BITS - 1) - bitcnt;
  assign mdio_oe  = run & (bitcnt < CNT_W'(DRIVE_BITS));
  assign mdio_o   = mdio_oe ? hdr[hdr_idx] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      bitcnt  <= '0;
      tag_q   <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      rd_data <= '0;
      rd_tag  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        run    <= 1'b1;
        bitcnt <= '0;
        tag_q  <= next_tag;
      end else if (fall && run) begin
        bitcnt <= bitcnt + CNT_W'(1);
      end
      if (rise && run && bitcnt >= CNT_W'(DATA_FIRST)) begin
        shreg <= {shreg[DATA_W-2:0], mdio_i};
        if (last_bit) begin
          done    <= 1'b1;
          rd_data <= {shreg[DATA_W-2:0], mdio_i};
          rd_tag  <= tag_q;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_link_monitor.sv
module mdio_link_monitor
  import mdio_mon_pkg::*;
#(
  parameter int HALF_W   = 8,
  parameter int DEF_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);
  logic [ADDR_W-1:0]  watch_q;
  logic               irq_en_q;
  logic [HALF_W-1:0]  half_q;
  logic [PHY_CNT-1:0] present_q;
  logic               link_q;
  logic               ev_q;

  logic               mdc_rise, mdc_fall, eng_load, eng_done;
  logic [DATA_W-1:0]  eng_data;
  frame_tag_t         eng_tag, sched_tag;
  logic               wr_ctrl, clr_ev, change;
  logic               unused_wbits;

  mdio_clk_div #(.HALF_W(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_n), .half(half_q),
    .mdc(mdc), .rise(mdc_rise), .fall(mdc_fall)
  );

  mdio_sched u_sched (
    .clk(clk), .rst_n(rst_n), .load(eng_load),
    .watch(watch_q), .next_tag(sched_tag)
  );

  mdio_read_engine u_eng (
    .clk(clk), .rst_n(rst_n), .rise(mdc_rise), .fall(mdc_fall),
    .next_tag(sched_tag), .load(eng_load),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .done(eng_done), .rd_data(eng_data), .rd_tag(eng_tag)
  );

  assign wr_ctrl = reg_we && (reg_addr == SEL_CTRL);
  assign clr_ev  = reg_we && (reg_addr == SEL_STATUS) && reg_wdata[1];
  assign change  = eng_done && eng_tag.mon && (eng_data[LINK_POS] != link_q);
  assign irq     = ev_q & irq_en_q;
  assign unused_wbits = ^{reg_wdata[31:16+HALF_W], reg_wdata[15:9],
                          reg_wdata[7:5], reg_wdata[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      watch_q   <= '0;
      irq_en_q  <= 1'b0;
      half_q    <= HALF_W'(DEF_HALF);
      present_q <= '0;
      link_q    <= 1'b0;
      ev_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        watch_q  <= reg_wdata[ADDR_W-1:0];
        irq_en_q <= reg_wdata[8];
        half_q   <= reg_wdata[16 +: HALF_W];
      end
      if (eng_done && !eng_tag.mon)
        present_q[eng_tag.phy] <= (eng_data != {DATA_W{1'b1}});
      if (eng_done && eng_tag.mon)
        link_q <= eng_data[LINK_POS];
      ev_q <= change | (ev_q & ~clr_ev);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTRL: begin
        reg_rdata[ADDR_W-1:0]  = watch_q;
        reg_rdata[8]           = irq_en_q;
        reg_rdata[16 +: HALF_W] = half_q;
      end
      SEL_PRESENT: reg_rdata = present_q;
      SEL_STATUS:  reg_rdata[1:0] = {ev_q, link_q};
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_link_monitor_chk.sv
module mdio_link_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        done,
  input logic [31:0] present,
  input logic        ev,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata
);
  // R3: data line moves only on a falling MDC edge
  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  // R3: output enable moves only on a falling MDC edge
  assert_oe_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc));

  // R5: bitmap only changes after a completed read
  assert_bitmap_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(present) |-> $past(done));

  // R7: event only rises after a completed read
  assert_event_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev) |-> $past(done));

  // R8: a clear with no read landing leaves the flag low
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_we) && $past(reg_addr) == 2'd2 && $past(reg_wdata[1]) && !$past(done))
      |-> !ev);
endmodule

bind mdio_link_monitor mdio_link_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .done(eng_done), .present(present_q), .ev(ev_q),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/mdio_link_monitor_tb.sv
module mdio_link_monitor_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic        mdio_i = 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] pmask = 32'h8000_0A25;
  logic [31:0] linkv = 32'h0000_0020;
  logic [4:0]  watch_tb = 5'd5;
  logic [4:0]  cap_addr = 0;
  int rc = 0, cur_bit = -1, cur_frame = -1, frames_done = 0;
  bit frame_bad = 0;

  always #2.5 clk = ~clk;

  mdio_link_monitor #(.HALF_W(8), .DEF_HALF(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_val(input logic [4:0] a);
    if (!pmask[a]) return 16'hFFFF;
    if (a == 5'd31) return 16'hFFFB;
    return 16'h7800 | (16'(a) << 3) | (16'(linkv[a]) << 2);
  endfunction

  // PHY model: checks frame layout (R1, R2, R4) and drives read data
  initial begin
    forever begin
      @(posedge mdc); #1;
      rc++;
      if (rc >= 2) begin
        int b, f;
        logic [4:0] ea;
        logic eb;
        b = (rc - 2) % 64;
        f = (rc - 2) / 64;
        ea = (f % 2 == 0) ? 5'((f / 2) % 32) : watch_tb;
        if (b == 0) frame_bad = 0;
        if (b < 46) begin
          if (b < 32) eb = 1;
          else if (b == 32 || b == 35) eb = 0;
          else if (b < 36) eb = 1;
          else if (b < 41) eb = ea[40 - b];
          else eb = (b == 45);
          if (mdio_oe !== 1'b1 || mdio_o !== eb) frame_bad = 1;
          if (b >= 36 && b <= 40) cap_addr[40 - b] = mdio_o;
        end else if (mdio_oe !== 1'b0) frame_bad = 1;
        cur_bit = b;
        cur_frame = f;
        if (b == 63) begin
          check("R1 R2 R4 frame layout", {31'd0, frame_bad}, 32'd0);
          frames_done = f + 1;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge mdc); #1;
      if (rc >= 1) begin
        int nb;
        logic [15:0] v;
        nb = (rc - 1) % 64;
        v = phy_val(cap_addr);
        mdio_i = (nb >= 48) ? v[15 - (nb - 48)] : 1'b1;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_frames(input int n);
    int target;
    target = frames_done + n;
    wait (frames_done >= target);
    @(posedge clk); #1;
  endtask

  task automatic wait_mon();
    int start;
    start = frames_done;
    forever begin
      wait (frames_done > start);
      start = frames_done;
      if ((frames_done - 1) % 2 == 1) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic check_map(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(2'd1, d);
    for (int a = 0; a < 32; a++) check(req, {31'd0, d[a]}, {31'd0, exp[a]});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk); #1;
    // R10 reset values
    rd(2'd0, d); check("R10 ctrl reset", d, 32'h0002_0000);
    rd(2'd1, d); check("R5 bitmap reset", d, 32'h0);
    rd(2'd2, d); check("R6 R7 status reset", d, 32'h0);
    check("R9 irq reset", {31'd0, irq}, 32'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R2 oe idle", {31'd0, mdio_oe}, 32'd0);
    wr(2'd0, 32'h0002_0005);
    rd(2'd0, d); check("R10 ctrl readback", d, 32'h0002_0005);

    // R3 divider H=2
    @(posedge mdc); n = 0;
    do begin @(posedge clk); #1; n++; end while (mdc);
    check("R3 high time H=2", n, 2);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!mdc);
    check("R3 low time H=2", n, 2);

    // full sweep, first population
    wait_frames(66);
    check_map("R5 sweep map A", pmask);
    rd(2'd2, d); check("R6 R7 first poll link=1 event", d, 32'h3);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'h0);
    rd(2'd1, d); check("R10 bitmap write ignored", d, pmask);

    wr(2'd0, 32'h0002_0105);
    check("R9 irq enabled", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h0000_0001);
    rd(2'd2, d); check("R8 write 0 ignored", d[1], 1'b1);
    wr(2'd2, 32'h0000_0002);
    rd(2'd2, d); check("R8 clear", d, 32'h1);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);

    // R3 divider H=3, H=0
    wr(2'd0, 32'h0003_0105);
    repeat (2) @(posedge mdc);
    @(posedge mdc); #1; n = 0;
    do begin @(posedge clk); #1; n++; end while (mdc);
    check("R3 high time H=3", n, 3);
    wr(2'd0, 32'h0000_0105);
    repeat (2) @(posedge mdc);
    @(posedge mdc); #1; n = 0;
    do begin @(posedge clk); #1; n++; end while (mdc);
    check("R3 high time H=0 acts as 1", n, 1);
    wr(2'd0, 32'h0002_0105);

    // second population
    pmask = 32'h4001_5025;
    wait_frames(66);
    check_map("R5 sweep map B", pmask);

    // R6 R7 link drop
    linkv[5] = 0;
    wait_frames(1);
    wait_mon();
    rd(2'd2, d); check("R6 R7 link drop", d, 32'h2);
    check("R9 irq on drop", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h2);
    wait_mon(); wait_mon();
    rd(2'd2, d); check("R7 no change no event", d, 32'h0);

    // R8 clear colliding with change
    linkv[5] = 1;
    wait_frames(1); wait_mon();
    rd(2'd2, d); check("R7 link restore", d, 32'h3);
    linkv[5] = 0;
    wait_frames(1);
    forever begin
      @(posedge mdc); #2;
      if (cur_bit == 63 && cur_frame % 2 == 1) break;
    end
    reg_addr = 2'd2; reg_wdata = 32'h2; reg_we = 1;
    @(posedge clk); #1; reg_we = 0;
    rd(2'd2, d); check("R8 change wins over clear", d, 32'h2);

    finish_run();
  end
endmodule